// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block tracks the reservation of one processor port for load-linked / store-conditional sequences. It receives one request per cycle: a reserving load, a conditional store, a reservation clear or a plain store. Each request carries a physical address. For every conditional store the block reports pass or fail one cycle later. It also drives the write strobe that lets the real memory write go ahead.

The reservation covers one aligned granule of `GRANULE_BYTES` bytes, a power of two from 8 to 2048. Addresses are compared only above the granule offset bits. With `TRACK_ADDR` set to 0 the monitor keeps no address. It is then a single flag that covers the whole address space, and plain stores cannot break it.

Top module: `excl_monitor`

## Requirements
- R1: A request with op code 0 (reserving load) puts the monitor in the reserved state and records the granule of its address.
- R2: A request with op code 1 (conditional store) always leaves the monitor open afterwards, whether it passed or failed.
- R3: A request with op code 2 (clear) leaves the monitor open and produces no memory write strobe.
- R4: A conditional store made while the monitor is open fails and produces no memory write strobe.
- R5: Two addresses that differ only in the low log2(GRANULE_BYTES) bits belong to the same granule. Addresses that differ above those bits belong to different granules.
- R6: In tracking mode, a request with op code 3 (plain store) to the reserved granule opens the monitor. A plain store to any other granule leaves the reservation in place.
- R7: With no address tracking, a conditional store passes whenever the monitor is reserved, whatever its address. Plain stores do not affect the reservation.
- R8: In tracking mode, a conditional store to a granule other than the recorded one fails, even while the monitor is reserved.
- R9: One cycle after a conditional store, `sc_valid` is 1 and `sc_fail` is 0 on success or 1 on failure. One cycle after a plain store or a passing conditional store, `mem_we` is 1 and `mem_addr` holds the request address. In every other cycle `sc_valid` and `mem_we` are 0.
- R10: A second reserving load replaces the recorded granule. After reset the monitor is open and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 reserving load, 1 conditional store, 2 clear, 3 plain store |
| req_addr | input | ADDR_W | Physical address of the request |
| sc_valid | output | 1 | Conditional store result is valid |
| sc_fail | output | 1 | 0 when the conditional store passed, 1 when it failed |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Address for the memory write |

## Verification
The bench builds two copies with a 12-bit address and 8-byte granules. One copy tracks addresses and the other does not, and both receive the same stimulus. A sweep places a plain store at every offset from 0 to 23 between a reserving load and a conditional store. This reaches both sides of the granule boundary and compares the two modes on each offset. Directed sequences then cover an open monitor, a clear, a mismatched granule, a replaced reservation and back-to-back conditional stores.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_RESERVE = 2'd0,
    OP_COND_ST = 2'd1,
    OP_CLEAR   = 2'd2,
    OP_STORE   = 2'd3
  } excl_op_e;
endpackage

// File: rtl/excl_granule_match.sv
module excl_granule_match #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 6,
  parameter bit TRACK  = 1'b1
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-OFS_W-1:0] held_tag,
  output logic [ADDR_W-OFS_W-1:0] addr_tag,
  output logic                    hit
);
  assign addr_tag = addr[ADDR_W-1:OFS_W];
  generate
    if (TRACK) begin : g_cmp
      assign hit = (addr_tag == held_tag);
    end else begin : g_any
      assign hit = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/excl_reserve_state.sv
module excl_reserve_state #(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic             clr,
  input  logic [TAG_W-1:0] new_tag,
  output logic             reserved,
  output logic [TAG_W-1:0] tag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reserved <= 1'b0;
      tag_q    <= '0;
    end else if (set) begin
      reserved <= 1'b1;
      tag_q    <= new_tag;
    end else if (clr) begin
      reserved <= 1'b0;
    end
  end

  assert_reserve_sets_R1: assert property (@(posedge clk) disable iff (rst)
    set |=> reserved && tag_q == $past(new_tag));
  assert_clear_opens_R2: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !reserved);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W        = 32,
  parameter int GRANULE_BYTES = 64,
  parameter bit TRACK_ADDR    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              sc_valid,
  output logic              sc_fail,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr
);
  import excl_pkg::*;

  localparam int OFS_W = $clog2(GRANULE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;

  generate
    if (GRANULE_BYTES < 8 || GRANULE_BYTES > 2048 ||
        (GRANULE_BYTES & (GRANULE_BYTES - 1)) != 0) begin : g_bad_granule
      $error("GRANULE_BYTES must be a power of two from 8 to 2048");
    end
  endgenerate

  logic [TAG_W-1:0] tag_q, addr_tag;
  logic hit, reserved;
  logic is_res, is_cst, is_clr, is_st;
  logic pass, st_hit;

  assign is_res = req_valid && (req_op == OP_RESERVE);
  assign is_cst = req_valid && (req_op == OP_COND_ST);
  assign is_clr = req_valid && (req_op == OP_CLEAR);
  assign is_st  = req_valid && (req_op == OP_STORE);

  excl_granule_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .TRACK(TRACK_ADDR)) match_i (
    .addr(req_addr), .held_tag(tag_q), .addr_tag(addr_tag), .hit(hit)
  );

  assign pass   = is_cst && reserved && hit;
  assign st_hit = TRACK_ADDR && is_st && hit;

  excl_reserve_state #(.TAG_W(TAG_W)) state_i (
    .clk(clk), .rst(rst), .set(is_res),
    .clr(is_cst || is_clr || st_hit),
    .new_tag(addr_tag), .reserved(reserved), .tag_q(tag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_valid <= 1'b0;
      sc_fail  <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      sc_valid <= is_cst;
      sc_fail  <= is_cst && !pass;
      mem_we   <= is_st || pass;
      mem_addr <= req_addr;
    end
  end

  assert_open_fails_R4: assert property (@(posedge clk) disable iff (rst)
    (is_cst && !reserved) |=> sc_valid && sc_fail && !mem_we);
  assert_cond_opens_R2: assert property (@(posedge clk) disable iff (rst)
    is_cst |=> !reserved);
  assert_clear_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    is_clr |=> !reserved && !mem_we && !sc_valid);
  assert_status_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    sc_valid |-> $past(is_cst));
  assert_fail_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && sc_fail) |-> !mem_we);
endmodule

// File: tb/excl_monitor_tb_top.sv
module excl_monitor_tb_top;
  localparam int AW = 12;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic sv_t, sf_t, we_t, sv_n, sf_n, we_n;
  logic [AW-1:0] ma_t, ma_n;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .GRANULE_BYTES(8), .TRACK_ADDR(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .sc_valid(sv_t), .sc_fail(sf_t), .mem_we(we_t), .mem_addr(ma_t));
  excl_monitor #(.ADDR_W(AW), .GRANULE_BYTES(8), .TRACK_ADDR(1'b0)) dut_nt (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .sc_valid(sv_n), .sc_fail(sf_n), .mem_we(we_n), .mem_addr(ma_n));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge; outputs are sampled at the next falling edge
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a);
    req_valid = 1'b1; req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cond_check(input string tag, input logic [AW-1:0] a,
                            input bit pass_t, input bit pass_n);
    issue(2'd1, a);
    chk({tag, " valid track"}, sv_t, 1);
    chk({tag, " fail track"}, sf_t, !pass_t);
    chk({tag, " we track"}, we_t, pass_t);
    chk({tag, " valid notrack"}, sv_n, 1);
    chk({tag, " fail notrack"}, sf_n, !pass_n);
    chk({tag, " we notrack"}, we_n, pass_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 reset sc_valid", sv_t, 0);
    chk("R10 reset mem_we", we_t, 0);
    chk("R10 reset mem_addr", ma_t, 0);
    @(negedge clk);
    chk("R9 idle no strobe", sv_t | we_t | sv_n | we_n, 0);
    // R4 open after reset
    cond_check("R4 open", 12'h040, 0, 0);

    // R5 R6 R7 sweep of plain store offsets against the reserved granule
    for (int d = 0; d < 24; d++) begin
      bit inside_g;
      inside_g = ((12'h100 + d) >> 3) == (12'h100 >> 3);
      issue(2'd0, 12'h100 + 12'((d * 3) % 8));
      issue(2'd3, 12'h100 + 12'(d));
      chk("R9 store we", we_t, 1);
      chk("R9 store addr", ma_t, 12'h100 + d);
      cond_check(inside_g ? "R6 R5 inside" : "R6 R5 outside", 12'h107, !inside_g, 1);
    end

    // R2 second conditional store after a pass fails
    issue(2'd0, 12'h200);
    cond_check("R2 first", 12'h200, 1, 1);
    cond_check("R2 second", 12'h200, 0, 0);

    // R3 clear
    issue(2'd0, 12'h300);
    issue(2'd2, 12'h300);
    chk("R3 clear no we", we_t | we_n, 0);
    chk("R3 clear no valid", sv_t | sv_n, 0);
    cond_check("R3 after clear", 12'h300, 0, 0);

    // R8 R7 different granule
    issue(2'd0, 12'h400);
    cond_check("R8 R7 other granule", 12'h408, 0, 1);

    // R10 replaced reservation
    issue(2'd0, 12'h500);
    issue(2'd0, 12'h600);
    cond_check("R10 old granule", 12'h500, 0, 1);
    issue(2'd0, 12'h500);
    issue(2'd0, 12'h600);
    cond_check("R10 new granule", 12'h604, 1, 1);

    // R1 reservation needs a preceding reserving load
    issue(2'd0, 12'h7F8);
    cond_check("R1 reserve then cond", 12'h7FF, 1, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule